// File: doc/BRIEF.md
# Fractional Tick Divider with Source Select

This block takes ten tick streams. Each stream is a train of single-cycle enable pulses in the system clock domain. The block picks one stream and divides its rate by a value that has an integer part and a fractional part. The result leaves the block as a new tick stream. A phase accumulator spreads the fractional remainder over time, so the long-run output rate is the source rate times 2^FRAC_BITS divided by the divider value.

Software sets the block up through two 32-bit registers on a small register port:
- The control word holds the enable bit, the source select and a read-only busy flag.
- The divider word holds the packed divider value.

Writes are single-cycle strobes, and read data is combinational. An instance built with INT_BITS = FRAC_BITS = 0 has no divider and forwards the selected stream unchanged.

Top module: `tick_divider`

## Requirements
- R1: After reset, enable is 0, source select is 0, the stored divider word is 0, both registers read 0 and tickOut is 0.
- R2: Control word (address 0): bit 0 is enable and bits [7:4] are the source select. Both read back as written. Bits [3:2] and [31:8] read as 0.
- R3: Control bit 1 is a read-only busy flag that always equals the enable bit. Writes to bit 1 have no effect on it.
- R4: While enable is 0, tickOut stays 0 whatever the sources do.
- R5: Divider word (address 1): the fraction sits in bits [11:0] and the integer in bits [23:12]. Bits [23:0] read back as written and bits [31:24] read as 0. The effective divider is (word >> (12 - FRAC_BITS)) masked to INT_BITS + FRAC_BITS bits.
- R6: Each selected source tick adds 2^FRAC_BITS to an accumulator. When the sum reaches or exceeds the divider value, tickOut pulses in the next cycle and the divider value is subtracted. Otherwise the sum is kept.
- R7: When the effective divider value is 0, tickOut stays 0.
- R8: When the divider value is nonzero and not above 2^FRAC_BITS, every selected source tick gives one output tick, and the accumulator stays 0.
- R9: Ticks on unselected sources never reach tickOut. Select codes 10 to 15 choose no source.
- R10: Any register write clears the accumulator. A source tick in the same cycle as the write is discarded.
- R11: With INT_BITS = FRAC_BITS = 0, tickOut is the selected, enabled source tick delayed by one cycle. The divider word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | NUM_SRC | Source tick streams, one bit each |
| regWrEn | input | 1 | Single-cycle register write strobe |
| regAddr | input | 1 | 0 selects control, 1 selects divider |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| tickOut | output | 1 | Divided output tick |

## Verification
The bench aims at several corner cases:
- A divider whose fraction sits just below the masked-off low bits. Wrong field extraction would give a nonzero divider and spurious ticks where the output should stay silent.
- Dividers at or below 2^FRAC_BITS. Mishandling them would let the accumulator drift upward, so ticks would go missing or the accumulator would overflow.
- A write landing together with a source tick. A design that does not clear state on writes would emit an early tick after the rate changes.
- Select codes beyond the tenth source, and activity on unselected inputs. A loose multiplexer would leak those ticks to the output.

A bypass instance is driven with the same stimulus to confirm that it ignores the divider.

// File: rtl/tickdiv_pkg.sv
package tickdiv_pkg;
  // Fixed register layout constants
  localparam int FIELD_W = 12;   // width of each divider field
  localparam int SEL_W   = 4;    // source select width, bits [7:4]

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAcc;   // any register write this cycle
    logic run;      // enable bit
  } dpStrobe_t;
endpackage

// File: rtl/tickdiv_ctrl.sv
module tickdiv_ctrl
  import tickdiv_pkg::*;
#(
  parameter int INT_BITS  = 12,
  parameter int FRAC_BITS = 12,
  parameter int DV_W      = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output dpStrobe_t            strobe,
  output logic [SEL_W-1:0]     srcSel,
  output logic [DV_W-1:0]      divVal
);
  localparam int DIV_W  = INT_BITS + FRAC_BITS;
  localparam int WORD_W = 2 * FIELD_W;

  logic              ctlEn;
  logic [SEL_W-1:0]  ctlSel;
  logic [WORD_W-1:0] divWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlEn   <= 1'b0;
      ctlSel  <= '0;
      divWord <= '0;
    end else if (regWrEn) begin
      if (!regAddr) begin
        ctlEn  <= regWrData[0];
        ctlSel <= regWrData[7:4];
      end else begin
        divWord <= regWrData[WORD_W-1:0];
      end
    end
  end

  always_comb begin
    if (!regAddr) regRdData = {24'd0, ctlSel, 2'b00, ctlEn, ctlEn};
    else          regRdData = {8'd0, divWord};
  end

  assign strobe.clrAcc = regWrEn;
  assign strobe.run    = ctlEn;
  assign srcSel        = ctlSel;

  generate
    if (DIV_W > 0) begin : g_extract
      logic [WORD_W-1:0] shifted;
      assign shifted = divWord >> (FIELD_W - FRAC_BITS);
      assign divVal  = shifted[DV_W-1:0];
    end else begin : g_nodiv
      assign divVal = '0;
    end
  endgenerate

  // R3: busy flag mirrors enable in the readback
  assert_busy_mirror_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 1'b0) |-> (regRdData[1] == regRdData[0]));

  // R5: reserved divider bits always read zero
  assert_div_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
    regAddr |-> (regRdData[31:24] == 8'd0));
endmodule

// File: rtl/tickdiv_path.sv
module tickdiv_path
  import tickdiv_pkg::*;
#(
  parameter int NUM_SRC   = 10,
  parameter int INT_BITS  = 12,
  parameter int FRAC_BITS = 12,
  parameter int DV_W      = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  dpStrobe_t          strobe,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [DV_W-1:0]    divVal,
  output logic               tickOut
);
  localparam int DIV_W = INT_BITS + FRAC_BITS;

  logic selTick;

  always_comb begin
    selTick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (srcSel == SEL_W'(i)) selTick = srcTick[i];
  end

  generate
    if (DIV_W == 0) begin : g_bypass
      logic unusedDiv;
      assign unusedDiv = ^divVal;

      always_ff @(posedge clk) begin
        if (!rstN)              tickOut <= 1'b0;
        else if (strobe.clrAcc) tickOut <= 1'b0;
        else                    tickOut <= strobe.run & selTick;
      end
    end else begin : g_accum
      localparam int ACC_W = DIV_W + 1;
      logic [ACC_W-1:0] acc, sum, step, div;

      assign step = ACC_W'(1) << FRAC_BITS;
      assign div  = ACC_W'(divVal);
      assign sum  = acc + step;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          acc     <= '0;
          tickOut <= 1'b0;
        end else if (strobe.clrAcc) begin
          acc     <= '0;
          tickOut <= 1'b0;
        end else if (strobe.run && selTick && div != '0) begin
          if (sum >= div) begin
            tickOut <= 1'b1;
            acc     <= (div <= step) ? '0 : sum - div;
          end else begin
            tickOut <= 1'b0;
            acc     <= sum;
          end
        end else begin
          tickOut <= 1'b0;
        end
      end

      // R6: the accumulator stays below the divider value
      assert_acc_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
        (acc == '0) || (acc < div));

      // R7: a zero divider keeps the output silent
      assert_zero_div_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
        (div == '0) |=> !tickOut);

      // R10: a write leaves a cleared accumulator and no tick
      assert_write_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
        strobe.clrAcc |=> (acc == '0 && !tickOut));
    end
  endgenerate

  // R4: no output while disabled
  assert_no_tick_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> !tickOut);

  // R9: every output tick comes from a selected source tick
  assert_tick_from_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> $past(selTick));
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tickdiv_pkg::*;
#(
  parameter int NUM_SRC   = 10,
  parameter int INT_BITS  = 12,
  parameter int FRAC_BITS = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               tickOut
);
  localparam int DIV_W = INT_BITS + FRAC_BITS;
  localparam int DV_W  = (DIV_W > 0) ? DIV_W : 1;

  dpStrobe_t        strobe;
  logic [SEL_W-1:0] srcSel;
  logic [DV_W-1:0]  divVal;

  tickdiv_ctrl #(
    .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS), .DV_W(DV_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .srcSel(srcSel), .divVal(divVal)
  );

  tickdiv_path #(
    .NUM_SRC(NUM_SRC), .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS), .DV_W(DV_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .strobe(strobe),
    .srcSel(srcSel), .divVal(divVal), .tickOut(tickOut)
  );
endmodule

// File: tb/sim_tick_divider.sv
module sim_tick_divider;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] srcTick = '0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] rd0, rd1;
  logic tick0, tick1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  tick_divider #(.NUM_SRC(10), .INT_BITS(6), .FRAC_BITS(4)) u0 (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rd0), .tickOut(tick0));

  tick_divider #(.NUM_SRC(10), .INT_BITS(0), .FRAC_BITS(0)) u1 (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rd1), .tickOut(tick1));

  // Bench-side model, shared control state for both instances
  bit mEn = 0;
  int mSel = 0;
  int mWord = 0;
  int mAcc = 0;
  int outCount = 0;

  function automatic int effDiv(int word);
    return (word >> 8) & 10'h3FF;   // FRAC_BITS=4, INT_BITS=6
  endfunction

  task automatic check(bit cond, string tag, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] src, input bit wr, input bit addr,
                      input logic [31:0] data, input string tag);
    bit e0, e1, hit;
    int dv, sum;
    @(negedge clk);
    srcTick = src; regWrEn = wr; regAddr = addr; regWrData = data;
    hit = mEn && (mSel < 10) && src[mSel];
    e0 = 0; e1 = 0;
    if (wr) begin
      mAcc = 0;
      if (!addr) begin mEn = data[0]; mSel = int'(data[7:4]); end
      else mWord = int'(data[23:0]);
    end else begin
      e1 = hit;
      dv = effDiv(mWord);
      if (hit && dv != 0) begin
        sum = mAcc + 16;
        if (sum >= dv) begin e0 = 1; mAcc = (dv <= 16) ? 0 : sum - dv; end
        else mAcc = sum;
      end
    end
    @(posedge clk); #1;
    check(tick0 == e0, tag, tick0, e0);
    check(tick1 == e1, "R11", tick1, e1);
    if (tick0) outCount++;
    regWrEn = 1'b0;
  endtask

  task automatic readChk(input bit addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = addr; #1;
    check(rd0 == exp, tag, rd0, exp);
  endtask

  function automatic logic [31:0] ctlExp(bit en, int sel);
    return {24'd0, 4'(sel), 2'b00, en, en};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    readChk(0, 32'h0, "R1");
    readChk(1, 32'h0, "R1");
    check(tick0 == 0 && tick1 == 0, "R1", tick0, 0);

    // R2/R3 control layout, busy read-only
    step(10'h0, 1, 0, 32'hFFFF_FF2F, "R2");
    readChk(0, ctlExp(1, 2), "R3");
    step(10'h0, 1, 0, 32'h0000_0023, "R2");
    readChk(0, ctlExp(1, 2), "R2");

    // R5 divider layout: int 3, frac 0x800 -> 56
    step(10'h0, 1, 1, 32'hFF00_3800, "R5");
    readChk(1, 32'h0000_3800, "R5");

    // R6 rate: 70 selected ticks at 16/56 -> 20 outputs
    outCount = 0;
    for (int i = 0; i < 70; i++) step(10'h004, 0, 0, 0, "R6");
    check(outCount == 20, "R6", outCount, 20);

    // R9 unselected sources
    for (int i = 0; i < 20; i++) step(10'h3FB, 0, 0, 0, "R9");
    step(10'h0, 1, 0, 32'h0000_00C1, "R9");
    for (int i = 0; i < 10; i++) step(10'h3FF, 0, 0, 0, "R9");
    step(10'h0, 1, 0, 32'h0000_0021, "R2");

    // R7 zero divider (bits below the fraction field are masked away)
    step(10'h0, 1, 1, 32'h0000_00FF, "R7");
    outCount = 0;
    for (int i = 0; i < 12; i++) step(10'h004, 0, 0, 0, "R7");
    check(outCount == 0, "R7", outCount, 0);

    // R8 divider at or below 2^FRAC_BITS
    step(10'h0, 1, 1, 32'h0000_1000, "R8");
    outCount = 0;
    for (int i = 0; i < 10; i++) step(10'h004, 0, 0, 0, "R8");
    check(outCount == 10, "R8", outCount, 10);
    step(10'h0, 1, 1, 32'h0000_0500, "R8");
    outCount = 0;
    for (int i = 0; i < 10; i++) step(10'h004, 0, 0, 0, "R8");
    check(outCount == 10, "R8", outCount, 10);

    // R4 disabled
    step(10'h0, 1, 0, 32'h0000_0020, "R4");
    readChk(0, ctlExp(0, 2), "R3");
    outCount = 0;
    for (int i = 0; i < 10; i++) step(10'h3FF, 0, 0, 0, "R4");
    check(outCount == 0, "R4", outCount, 0);

    // R10 write with coincident tick clears the accumulator
    step(10'h0, 1, 0, 32'h0000_0021, "R10");
    step(10'h0, 1, 1, 32'h0000_3800, "R10");
    for (int i = 0; i < 3; i++) step(10'h004, 0, 0, 0, "R10");
    step(10'h004, 1, 1, 32'h0000_3800, "R10");
    for (int i = 0; i < 4; i++) step(10'h004, 0, 0, 0, "R10");

    // Random mix, checked every cycle against the model (R6)
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3)
        step(10'($urandom), 1, 0, {$urandom} & 32'h0000_00F1 | 32'h1, "R6");
      else if (r < 6)
        step(10'($urandom), 1, 1, {8'd0, 3'd0, 3'($urandom), 12'($urandom)}, "R6");
      else
        step(10'($urandom), 0, 0, 0, "R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule